// File: doc/BRIEF.md
# EDO Page-Mode DRAM Controller

This block lets a synchronous host reach a 128K x 8 asynchronous DRAM with extended-data-out page mode. The host posts single-byte reads, writes and read-modify-writes on a valid/ready port. The controller turns each one into RAS, CAS, WE and OE strobe sequences on a shared 9-bit address bus. Every timing interval is a whole number of clock cycles set by a parameter, so the counts can be chosen to meet the part's page cycle, random cycle and access limits at the clock in use.

After an access the row stays open. A later request to the same row skips activation and runs as a short column cycle. A request to another row first precharges for a set number of cycles. Read data is captured after CAS has returned high, because the device holds its output past the strobe.

A free-running timer requests one refresh every `REF_INTERVAL` clocks. The default is 1562 clocks at 100 MHz, which gives 512 refreshes per 8 ms. Pending refreshes are counted and are served ahead of new host work. An open row is closed first. By default the refresh is CAS-before-RAS. Setting `RAS_ONLY_REF` instead drives a refresh row counter with RAS alone.

Top module: `edo_dram_ctrl`

## Requirements
- R1: While reset is held, all four strobes are high and `rsp_valid` is low. After reset, `req_ready` is high.
- R2: The address bits are split into a row and a column. Row `req_addr[16:8]` is on `dram_addr` when RAS falls. Column `req_addr[7:0]` is on `dram_addr[7:0]`, with the upper bit zero, when CAS falls. A read returns the byte last written to that address.
- R3: A request whose row matches the open row produces no new RAS activation. RAS stays low and only a CAS cycle is run.
- R4: RAS is high for at least `T_RP` cycles before every falling edge. CAS falls no earlier than `T_RCD` cycles after RAS falls on an activation.
- R5: Read data is captured with CAS high. `rsp_valid` only follows a cycle in which `dram_cas_n` was high.
- R6: `req_op` selects the operation: 00 is read, 01 is write, and 1x is read-modify-write. A read-modify-write returns the old byte and stores the new byte within one unbroken CAS-low period, with WE falling while CAS is low.
- R7: A refresh lowers CAS before RAS. Exactly one refresh occurs per `REF_INTERVAL` clocks on average, to within one.
- R8: While any refresh is pending, `req_ready` is low. Under continuous host traffic, the refresh rate still meets R7.
- R9: WE is low only while RAS is low, and only while `dram_dq_oe` drives the data bus.
- R10: OE and WE are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted this cycle when high with valid |
| req_op | input | 2 | 00 read, 01 write, 1x read-modify-write |
| req_addr | input | 17 | Byte address, row in upper 9 bits |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | 8 | Read data (old byte for read-modify-write) |
| dram_addr | output | 9 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | 8 | Data to the device |
| dram_dq_oe | output | 1 | Drive enable for `dram_dq_out` |
| dram_dq_in | input | 8 | Data from the device |

## Verification
The bench runs same-row request bursts directly after a refresh and counts RAS activations. A controller that reopened the row on a hit would show extra activations, and one that missed a row change would return bytes from the wrong row. Read-modify-writes are followed by reads of the same byte. A late write outside the CAS-low period, or a capture before WE, would return the wrong old or new value. Refresh counts are compared against elapsed cycles, both idle and under back-to-back traffic. A scheduler that let host work starve refresh, or lost pending ticks, falls outside the one-refresh tolerance. A behavioural device model flags short precharges, a short RAS-to-CAS gap, and overlapping OE and WE.

// File: rtl/edo_dram_ctrl.sv
module edo_dram_ctrl #(
  parameter int ROW_W        = 9,
  parameter int COL_W        = 8,
  parameter int DATA_W       = 8,
  parameter int T_RP         = 4,
  parameter int T_RCD        = 2,
  parameter int T_CAS        = 2,
  parameter int T_CP         = 1,
  parameter int T_RAS_REF    = 5,
  parameter int REF_INTERVAL = 1562,
  parameter int PEND_W       = 4,
  parameter bit RAS_ONLY_REF = 1'b0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [1:0]             req_op,
  input  logic [ROW_W+COL_W-1:0] req_addr,
  input  logic [DATA_W-1:0]      req_wdata,
  output logic                   rsp_valid,
  output logic [DATA_W-1:0]      rsp_rdata,
  output logic [ROW_W-1:0]       dram_addr,
  output logic                   dram_ras_n,
  output logic                   dram_cas_n,
  output logic                   dram_we_n,
  output logic                   dram_oe_n,
  output logic [DATA_W-1:0]      dram_dq_out,
  output logic                   dram_dq_oe,
  input  logic [DATA_W-1:0]      dram_dq_in
);
  localparam int TMAX  = T_RP + T_RCD + T_CAS + T_CP + T_RAS_REF;
  localparam int CNT_W = $clog2(TMAX + 1);
  localparam int TMR_W = $clog2(REF_INTERVAL + 1);
  localparam logic [PEND_W-1:0] PMAX = '1;

  typedef enum logic [3:0] {S_IDLE, S_PRE, S_ACT, S_COLA, S_COL, S_RMWW, S_CASH, S_REFC, S_REFR} st_t;

  st_t               state;
  logic [CNT_W-1:0]  cnt;
  logic              open, have_req;
  logic [ROW_W-1:0]  open_row, ref_row;
  logic [COL_W-1:0]  col_q;
  logic [1:0]        op_q;
  logic [DATA_W-1:0] wd_q;
  logic [TMR_W-1:0]  tmr;
  logic [PEND_W-1:0] pend;

  wire [ROW_W-1:0] req_row = req_addr[ROW_W+COL_W-1:COL_W];
  wire is_wr   = (op_q == 2'b01);
  wire is_rmw  = op_q[1];
  wire tick    = (tmr == TMR_W'(REF_INTERVAL - 1));
  wire ref_done = (state == S_REFR) && (cnt == '0);

  assign req_ready   = (state == S_IDLE) && (pend == '0);
  assign dram_ras_n  = !(open || state == S_REFR);
  assign dram_cas_n  = !(state == S_COL || state == S_RMWW || (!RAS_ONLY_REF && (state == S_REFC || state == S_REFR)));
  assign dram_we_n   = !((state == S_COL && is_wr) || state == S_RMWW);
  assign dram_oe_n   = !((state == S_COL && !is_wr) || (state == S_CASH && !is_wr && !is_rmw));
  assign dram_dq_oe  = !dram_we_n;
  assign dram_dq_out = wd_q;
  assign dram_addr   = (state == S_ACT) ? open_row :
                       (RAS_ONLY_REF && state == S_REFR) ? ref_row : ROW_W'(col_q);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) tmr <= '0;
    else        tmr <= tick ? '0 : tmr + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                                   pend <= '0;
    else if (tick && !ref_done && pend != PMAX)   pend <= pend + 1'b1;
    else if (!tick && ref_done)                   pend <= pend - 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; cnt <= '0; open <= 1'b0; have_req <= 1'b0;
      open_row <= '0; ref_row <= '0; col_q <= '0; op_q <= '0; wd_q <= '0;
      rsp_valid <= 1'b0; rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (cnt != '0 && state != S_IDLE) cnt <= cnt - 1'b1;
      else case (state)
        S_IDLE:
          if (pend != '0) begin
            if (open) begin
              state <= S_PRE; cnt <= CNT_W'(T_RP - 1); open <= 1'b0;
            end else if (RAS_ONLY_REF) begin
              state <= S_REFR; cnt <= CNT_W'(T_RAS_REF - 1);
            end else begin
              state <= S_REFC; cnt <= CNT_W'(T_CP - 1);
            end
          end else if (req_valid) begin
            have_req <= 1'b1; op_q <= req_op; wd_q <= req_wdata;
            col_q <= req_addr[COL_W-1:0];
            if (open && req_row == open_row) state <= S_COLA;
            else if (open) begin
              state <= S_PRE; cnt <= CNT_W'(T_RP - 1); open <= 1'b0; open_row <= req_row;
            end else begin
              state <= S_ACT; cnt <= CNT_W'(T_RCD - 1); open <= 1'b1; open_row <= req_row;
            end
          end
        S_PRE:
          if (pend != '0) begin
            if (RAS_ONLY_REF) begin state <= S_REFR; cnt <= CNT_W'(T_RAS_REF - 1); end
            else begin state <= S_REFC; cnt <= CNT_W'(T_CP - 1); end
          end else if (have_req) begin
            state <= S_ACT; cnt <= CNT_W'(T_RCD - 1); open <= 1'b1;
          end else state <= S_IDLE;
        S_ACT:  state <= S_COLA;
        S_COLA: begin state <= S_COL; cnt <= CNT_W'(T_CAS - 1); end
        S_COL:
          if (is_rmw) begin
            rsp_rdata <= dram_dq_in; state <= S_RMWW; cnt <= CNT_W'(T_CAS - 1);
          end else begin
            state <= S_CASH; cnt <= CNT_W'(T_CP - 1);
          end
        S_RMWW: begin state <= S_CASH; cnt <= CNT_W'(T_CP - 1); end
        S_CASH: begin
          if (!is_wr && !is_rmw) rsp_rdata <= dram_dq_in;
          rsp_valid <= !is_wr;
          have_req  <= 1'b0;
          state     <= S_IDLE;
        end
        S_REFC: begin state <= S_REFR; cnt <= CNT_W'(T_RAS_REF - 1); end
        S_REFR: begin
          state <= S_PRE; cnt <= CNT_W'(T_RP - 1);
          if (RAS_ONLY_REF) ref_row <= ref_row + 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/edo_dram_ctrl_chk.sv
module edo_dram_ctrl_chk #(
  parameter int PEND_W = 4,
  parameter int T_RP   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic              oe_n,
  input logic              dq_oe,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [PEND_W-1:0] pend
);
  logic [7:0] hi_cnt;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      hi_cnt <= 8'(T_RP);
    else if (ras_n)  hi_cnt <= (hi_cnt == 8'hff) ? hi_cnt : hi_cnt + 1'b1;
    else             hi_cnt <= '0;

  // R4
  precharge_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> hi_cnt >= 8'(T_RP));
  // R5
  edo_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(cas_n));
  // R7
  cbr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && !cas_n) |-> $past(!cas_n));
  // R8
  refresh_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend != '0) |-> !req_ready);
  // R9
  write_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> (!ras_n && dq_oe));
  // R10
  oe_we_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!oe_n && !we_n));
endmodule

bind edo_dram_ctrl edo_dram_ctrl_chk #(.PEND_W(PEND_W), .T_RP(T_RP)) u_chk (
  .clk(clk), .rst_n(rst_n), .ras_n(dram_ras_n), .cas_n(dram_cas_n),
  .we_n(dram_we_n), .oe_n(dram_oe_n), .dq_oe(dram_dq_oe),
  .req_ready(req_ready), .rsp_valid(rsp_valid), .pend(pend)
);

// File: tb/edo_dram_ctrl_bench.sv
module edo_dram_ctrl_bench;
  localparam int TRP = 3, TRCD = 2, TCAS = 2, TCP = 1, TRR = 4, RINT = 200;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_ready;
  logic [1:0] req_op = 0;
  logic [16:0] req_addr = 0;
  logic [7:0] req_wdata = 0, rsp_rdata, dq_out, dq_in = 0;
  logic rsp_valid, ras_n, cas_n, we_n, oe_n, dq_oe;
  logic [8:0] addr;

  always #5 clk = ~clk;

  edo_dram_ctrl #(.T_RP(TRP), .T_RCD(TRCD), .T_CAS(TCAS), .T_CP(TCP),
                  .T_RAS_REF(TRR), .REF_INTERVAL(RINT)) u_edo_dram_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .dram_addr(addr),
    .dram_ras_n(ras_n), .dram_cas_n(cas_n), .dram_we_n(we_n), .dram_oe_n(oe_n),
    .dram_dq_out(dq_out), .dram_dq_oe(dq_oe), .dram_dq_in(dq_in));

  int tests = 0, fails = 0, cyc = 0;
  int acts = 0, refs = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // device model
  logic [7:0] mem [int];
  logic [7:0] shadow [int];
  logic [8:0] m_row = 0;
  logic [7:0] m_col = 0;
  logic p_ras = 1, p_cas = 1, p_we = 1;
  int hi = 100, rcd = 0;

  function automatic logic [7:0] rd_mem(int a);
    return mem.exists(a) ? mem[a] : 8'h00;
  endfunction

  always @(negedge clk) if (rst_n) begin
    if (p_ras && !ras_n) begin
      if (!cas_n) refs++;
      else begin m_row = addr; acts++; end
      chk(hi >= TRP, "R4 precharge", hi, TRP);
      rcd = 0;
    end
    if (p_cas && !cas_n && !ras_n) begin
      m_col = addr[7:0];
      chk(rcd >= TRCD, "R4 ras-to-cas", rcd, TRCD);
      if (!we_n) mem[{m_row, m_col}] = dq_out;
    end else if (p_we && !we_n && !cas_n && !ras_n && !p_cas)
      mem[{m_row, m_col}] = dq_out;
    if (!oe_n && !we_n) chk(0, "R10 oe/we overlap", 0, 1);
    hi  = ras_n ? hi + 1 : 0;
    rcd = ras_n ? 0 : rcd + 1;
    dq_in = rd_mem({m_row, m_col});
    p_ras = ras_n; p_cas = cas_n; p_we = we_n;
  end

  // scoreboard
  logic [7:0] expq [$];
  string tagq [$];

  always @(negedge clk) if (rst_n && rsp_valid) begin
    if (expq.size() == 0) chk(0, "R2 unexpected response", rsp_rdata, 0);
    else begin
      automatic logic [7:0] e = expq.pop_front();
      automatic string t = tagq.pop_front();
      chk(rsp_rdata == e, t, rsp_rdata, e);
    end
  end

  task automatic do_req(logic [1:0] op, logic [16:0] a, logic [7:0] wd, string tag);
    logic [7:0] old;
    old = shadow.exists(a) ? shadow[a] : 8'h00;
    @(negedge clk);
    req_valid = 1; req_op = op; req_addr = a; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    if (op != 2'b01) begin expq.push_back(old); tagq.push_back(tag); end
    if (op != 2'b00) shadow[a] = wd;
  endtask

  task automatic drain();
    while (expq.size() != 0) @(negedge clk);
    repeat (8) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++; tests++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int a0, r0, c0;
    repeat (3) @(negedge clk);
    // R1
    chk(ras_n && cas_n && we_n && oe_n, "R1 strobes in reset", {ras_n, cas_n, we_n, oe_n}, 15);
    chk(!rsp_valid, "R1 rsp in reset", rsp_valid, 0);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready, "R1 ready after reset", req_ready, 1);

    // R2 writes then reads across rows
    for (int i = 0; i < 6; i++) do_req(2'b01, 17'(i * 300 + 5), 8'(8'h30 + i * 7), "R2");
    for (int i = 0; i < 6; i++) do_req(2'b00, 17'(i * 300 + 5), 0, "R2 readback");
    do_req(2'b00, 17'h1ffff, 0, "R2 unwritten top address");
    do_req(2'b01, 17'h1ffff, 8'hc3, "R2");
    do_req(2'b00, 17'h00000, 0, "R2 bottom address");
    do_req(2'b00, 17'h1ffff, 0, "R2 top address");
    drain();

    // R3 page hits just after a refresh
    r0 = refs;
    while (refs == r0) @(negedge clk);
    repeat (12) @(negedge clk);
    a0 = acts;
    do_req(2'b01, 17'h0a5_00, 8'h11, "R3");
    do_req(2'b01, 17'h0a5_ff, 8'h22, "R3");
    do_req(2'b00, 17'h0a5_00, 0, "R3 hit read");
    do_req(2'b00, 17'h0a5_ff, 0, "R3 hit read");
    do_req(2'b00, 17'h0a5_40, 0, "R3 hit read");
    drain();
    chk(acts - a0 == 1, "R3 one activation for same-row burst", acts - a0, 1);
    a0 = acts;
    do_req(2'b00, 17'h0a6_00, 0, "R4 row change read");
    drain();
    chk(acts - a0 == 1, "R4 row change activates", acts - a0, 1);

    // R6 read-modify-write
    do_req(2'b10, 17'h0a6_10, 8'h5a, "R6 rmw old byte");
    do_req(2'b11, 17'h0a6_10, 8'h6b, "R6 rmw second");
    do_req(2'b00, 17'h0a6_10, 0, "R6 readback");
    do_req(2'b10, 17'h01f_03, 8'h77, "R6 rmw row miss");
    do_req(2'b00, 17'h01f_03, 0, "R6 readback");
    drain();

    // R7 idle refresh rate
    r0 = refs; c0 = cyc;
    repeat (4000) @(negedge clk);
    chk((refs - r0) >= (cyc - c0) / RINT - 1 && (refs - r0) <= (cyc - c0) / RINT + 1,
        "R7 idle refresh count", refs - r0, (cyc - c0) / RINT);

    // R8 refresh under continuous traffic
    r0 = refs; c0 = cyc;
    for (int i = 0; i < 400; i++) begin
      automatic logic [16:0] a = {9'($urandom % 4), 8'($urandom)};
      automatic logic [1:0] op = 2'($urandom % 3);
      do_req(op, a, 8'($urandom), "R8 traffic data");
    end
    chk((refs - r0) >= (cyc - c0) / RINT - 1 && (refs - r0) <= (cyc - c0) / RINT + 1,
        "R8 refresh count under traffic", refs - r0, (cyc - c0) / RINT);
    drain();
    chk(expq.size() == 0, "R2 all responses returned", expq.size(), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule